// File: doc/BRIEF.md
# Dual Event Counter with Coherent Snapshot

This block counts edges on two external event inputs. Each input is first brought into the clock domain through a two-flop synchronizer. An edge detector whose polarity software chooses then picks out the edges to count. Each selected edge adds one to that input's 16-bit counter. A cascade option joins the two counters into one 32-bit counter. In that mode only the first input counts, and the second counter takes the carry out of the first.

Software talks to the block through a byte-wide register port. The port has a write strobe and a combinational read path. Software cannot read the live counters directly. A capture request copies all four counter bytes into a snapshot in one cycle, so that a multi-byte read stays coherent while events keep arriving. Writes to the counter bytes preset or clear the live counters. While any write is in progress, counting is suspended, and an edge that falls in such a cycle is lost.

Top module: `edge_count_pair`

## Requirements
- R1: After reset, both counters, the snapshot and the control bits are zero, and every register address reads 0.
- R2: With polarity bit 0, each 0-to-1 transition on an input adds exactly 1 to its counter. The transition is seen after a two-flop synchronizer plus an edge register.
- R3: The control register is at 0Ch. Bit 0 selects the polarity of input A and bit 1 selects the polarity of input B, where 0 means rising and 1 means falling. An input held high after a rise does not count under falling polarity until it returns low.
- R4: With cascade off (0Ch bit 2 = 0), the two counters run independently. Each counter wraps from FFFFh to 0000h without affecting the other.
- R5: Writing 0Ch with bit 3 = 1 copies both counters into the snapshot in that cycle. Reads return the snapshot in little-endian order: 0Dh gives A[7:0], 0Eh gives A[15:8], 0Fh gives B[7:0] and 10h gives B[15:8]. The snapshot does not change until the next capture.
- R6: Reading 0Ch returns the stored bits 2..0. Bit 3 always reads 0 because the capture request clears itself, and bits 7..4 read 0.
- R7: A write to one of 0Dh..10h loads that byte of the live counter and leaves the other bytes as they were.
- R8: An edge that reaches the counter in a cycle with the write strobe high, at any address, is dropped and is not counted later.
- R9: With cascade on, counter A counts edges of input A. Counter B adds 1 when counter A wraps from FFFFh to 0000h, and input B is ignored.
- R10: Addresses other than 0Ch..10h read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_a | input | 1 | Event input A (asynchronous) |
| ev_b | input | 1 | Event input B (asynchronous) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |

## Verification
The collision that matters is a detected edge arriving in the same cycle as a register write. The block resolves it by dropping the edge. The bench provokes this by raising an event input and then holding the write strobe on an unused address across the whole synchronizer window. It then captures and judges that the counter has not moved. Preset writes and capture requests also fall close to pulse activity throughout the polarity and count sweep. Each resulting snapshot is compared with the preset plus the number of edges the chosen polarity should see.

// File: rtl/edge_count_pair.sv
module edge_count_pair #(
  parameter int AW = 5,
  parameter logic [AW-1:0] CTRL_ADDR = 5'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_a,
  input  logic          ev_b,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);
  localparam int CW = 16;
  localparam logic [AW-1:0] A_LO = CTRL_ADDR + AW'(1);
  localparam logic [AW-1:0] A_HI = CTRL_ADDR + AW'(2);
  localparam logic [AW-1:0] B_LO = CTRL_ADDR + AW'(3);
  localparam logic [AW-1:0] B_HI = CTRL_ADDR + AW'(4);

  logic [2:0]      sync_a, sync_b;
  logic [2:0]      ctrl;
  logic [CW-1:0]   cnt_a, cnt_b;
  logic [2*CW-1:0] snap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[1:0], ev_a};
      sync_b <= {sync_b[1:0], ev_b};
    end

  wire edge_a = ctrl[0] ? (~sync_a[1] & sync_a[2]) : (sync_a[1] & ~sync_a[2]);
  wire edge_b = ctrl[1] ? (~sync_b[1] & sync_b[2]) : (sync_b[1] & ~sync_b[2]);
  wire inc_a  = edge_a & ~bus_we;
  wire inc_b  = ctrl[2] ? (inc_a & (&cnt_a)) : (edge_b & ~bus_we);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl  <= '0;
      cnt_a <= '0;
      cnt_b <= '0;
      snap  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        CTRL_ADDR: begin
          ctrl <= bus_wdata[2:0];
          if (bus_wdata[3]) snap <= {cnt_b, cnt_a};
        end
        A_LO: cnt_a[7:0]  <= bus_wdata;
        A_HI: cnt_a[15:8] <= bus_wdata;
        B_LO: cnt_b[7:0]  <= bus_wdata;
        B_HI: cnt_b[15:8] <= bus_wdata;
        default: ;
      endcase
    end else begin
      if (inc_a) cnt_a <= cnt_a + 1'b1;
      if (inc_b) cnt_b <= cnt_b + 1'b1;
    end

  always_comb
    case (bus_addr)
      CTRL_ADDR: bus_rdata = {5'b0, ctrl};
      A_LO:      bus_rdata = snap[7:0];
      A_HI:      bus_rdata = snap[15:8];
      B_LO:      bus_rdata = snap[23:16];
      B_HI:      bus_rdata = snap[31:24];
      default:   bus_rdata = 8'h00;
    endcase
endmodule

module edge_count_pair_chk #(
  parameter int AW = 5,
  parameter logic [AW-1:0] CTRL_ADDR = 5'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [2:0]    ctrl,
  input logic [15:0]   cnt_a,
  input logic [15:0]   cnt_b,
  input logic [31:0]   snap
);
  wire cnt_addr = (bus_addr > CTRL_ADDR) && (bus_addr <= CTRL_ADDR + AW'(4));
  wire cap_req  = bus_we && bus_addr == CTRL_ADDR && bus_wdata[3];

  // R8
  no_count_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !cnt_addr) |=> ($stable(cnt_a) && $stable(cnt_b)));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 16'd1));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_req |=> $stable(snap));

  // R5
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req |=> snap == {$past(cnt_b), $past(cnt_a)});

  // R9
  cascade_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && !bus_we && cnt_a == 16'hFFFF) |=>
      ((cnt_a == 16'h0) ? (cnt_b == $past(cnt_b) + 16'd1) : (cnt_b == $past(cnt_b))));

  // R6
  ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_ADDR) |-> (bus_rdata[7:3] == 5'b0 && bus_rdata[2:0] == ctrl));
endmodule

bind edge_count_pair edge_count_pair_chk #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .snap(snap));

// File: tb/sim_edge_count_pair.sv
`timescale 1ns/1ps
module sim_edge_count_pair;
  logic clk = 1'b0, rst_n = 1'b0, ev_a = 1'b0, ev_b = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] ctl = '0;

  edge_count_pair u0 (.clk(clk), .rst_n(rst_n), .ev_a(ev_a), .ev_b(ev_b),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = '0;
  endtask

  task automatic rd16(input logic [4:0] base, output logic [15:0] v);
    @(negedge clk); bus_addr = base; #1 v[7:0] = bus_rdata;
    bus_addr = base + 5'd1; #1 v[15:8] = bus_rdata;
  endtask

  task automatic capture(); wr(5'h0C, ctl | 8'h08); endtask

  task automatic set_cnt(input logic [15:0] a, input logic [15:0] b);
    wr(5'h0D, a[7:0]); wr(5'h0E, a[15:8]); wr(5'h0F, b[7:0]); wr(5'h10, b[15:8]);
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic pulses(input int na, input int nb);
    for (int i = 0; i < ((na > nb) ? na : nb); i++) begin
      @(negedge clk); ev_a = (i < na); ev_b = (i < nb);
      repeat (2) @(negedge clk); ev_a = 0; ev_b = 0;
      repeat (2) @(negedge clk);
    end
    settle();
  endtask

  task automatic snap_both(output logic [15:0] a, output logic [15:0] b);
    capture(); rd16(5'h0D, a); rd16(5'h0F, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b;
    logic [7:0] r;
    repeat (3) @(negedge clk); rst_n = 1; settle();

    // R1 and R10: reset state and unused addresses
    for (int ad = 0; ad < 32; ad++) begin
      @(negedge clk); bus_addr = ad[4:0]; #1 r = bus_rdata;
      chk($sformatf("R1 R10 read addr %0h after reset", ad), {24'b0, r}, 32'h0);
    end

    // R2 R3 R4 R7: sweep over polarity settings and pulse counts
    for (int pol = 0; pol < 4; pol++)
      for (int na = 0; na < 5; na++)
        for (int nb = 0; nb < 5; nb++) begin
          ctl = pol[7:0]; wr(5'h0C, ctl);
          set_cnt(16'h00F0 + 16'(pol), 16'h7F00 + 16'(na));
          settle();
          pulses(na, nb);
          snap_both(a, b);
          chk($sformatf("R2 R3 R4 A pol=%0d na=%0d", pol, na), {16'b0, a}, 32'(16'h00F0 + 16'(pol) + 16'(na)));
          chk($sformatf("R2 R3 R4 B pol=%0d nb=%0d", pol, nb), {16'b0, b}, 32'(16'h7F00 + 16'(na) + 16'(nb)));
        end

    // R3: level distinction between polarities
    ctl = 8'h01; wr(5'h0C, ctl); set_cnt(0, 0); settle();
    @(negedge clk); ev_a = 1; ev_b = 1; settle();
    snap_both(a, b);
    chk("R3 falling A ignores rise", {16'b0, a}, 32'h0);
    chk("R3 rising B counts rise", {16'b0, b}, 32'h1);
    @(negedge clk); ev_a = 0; ev_b = 0; settle();
    snap_both(a, b);
    chk("R3 falling A counts fall", {16'b0, a}, 32'h1);
    chk("R3 rising B ignores fall", {16'b0, b}, 32'h1);

    // R6: control readback
    ctl = 8'h05; capture();
    @(negedge clk); bus_addr = 5'h0C; #1 r = bus_rdata;
    chk("R6 ctrl readback", {24'b0, r}, 32'h05);
    ctl = 8'h00; wr(5'h0C, 8'hF2);
    @(negedge clk); bus_addr = 5'h0C; #1 r = bus_rdata;
    chk("R6 ctrl upper bits", {24'b0, r}, 32'h02);
    wr(5'h0C, ctl);

    // R7: single byte write
    set_cnt(16'h1234, 16'h5678); wr(5'h0E, 8'hAB); wr(5'h0F, 8'hCD);
    snap_both(a, b);
    chk("R7 A high byte", {16'b0, a}, 32'hAB34);
    chk("R7 B low byte", {16'b0, b}, 32'h56CD);

    // R5: snapshot holds until next capture
    set_cnt(16'h0005, 16'h0009); capture();
    pulses(2, 3);
    rd16(5'h0D, a); rd16(5'h0F, b);
    chk("R5 snapshot hold A", {16'b0, a}, 32'h0005);
    chk("R5 snapshot hold B", {16'b0, b}, 32'h0009);
    snap_both(a, b);
    chk("R5 recapture A", {16'b0, a}, 32'h0007);
    chk("R5 recapture B", {16'b0, b}, 32'h000C);

    // R8: edge colliding with a write is dropped
    set_cnt(0, 0); settle();
    @(negedge clk); ev_a = 1; ev_b = 1; bus_we = 1; bus_addr = 5'h00; bus_wdata = 8'h00;
    repeat (6) @(negedge clk); bus_we = 0;
    settle();
    snap_both(a, b);
    chk("R8 edge A dropped in write", {16'b0, a}, 32'h0);
    chk("R8 edge B dropped in write", {16'b0, b}, 32'h0);
    @(negedge clk); ev_a = 0; ev_b = 0; settle();

    // R4: independent wrap
    set_cnt(16'hFFFF, 16'h0012); pulses(1, 0);
    snap_both(a, b);
    chk("R4 A wraps", {16'b0, a}, 32'h0);
    chk("R4 B untouched by A wrap", {16'b0, b}, 32'h0012);

    // R9: cascade
    ctl = 8'h04; wr(5'h0C, ctl);
    set_cnt(16'hFFFE, 16'h0012); pulses(3, 5);
    snap_both(a, b);
    chk("R9 cascade low", {16'b0, a}, 32'h0001);
    chk("R9 cascade high carry, B ignored", {16'b0, b}, 32'h0013);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule